// File: doc/BRIEF.md
# Fractional Resampler Timing Controller

This block sequences a fractional sample rate converter that runs from a single master clock. It keeps a wide fixed-point record of where the next output sample falls on the coefficient grid. That grid is the time axis whose spacing is the input spacing divided by the oversampling factor M. From this record it decides, cycle by cycle, whether the converter must first shift a fresh input sample into its register bank or may compute an output sample now.

For every output it supplies three values. The first is the polyphase branch that the coefficient selector uses; the second branch is always the next one modulo M. The second value is the base tap offset into the register bank. The third is the 16-bit linear interpolation weight between the two branches. Upsampling and downsampling use the same datapath; only the programmed step decides which kind of strobe dominates.

Software programs three things: the output spacing as a 70-bit ratio to the grid spacing, the oversampling factor as a power of two, and the number of outputs after which the output time lands exactly on an input instant. At that point the controller rebases its counters, which stops rounding error in the step from building up.

Top module: `rsc_timing_ctrl`

## Requirements
- R1: After a synchronous reset every output is zero: both strobes low, branch, tap base and fraction all 0.
- R2: While `run` is low no strobe is issued and the position and input count return to zero. After `run` rises again, the first output is computed at position 0 (branch 0, tap base 0, fraction 0) and exactly one write precedes it.
- R3: While `run` is high, each cycle issues exactly one strobe, either `wr_stb` or `cmp_stb` and never both, one cycle after the register edge that decided it.
- R4: Before output k is computed, the number of writes since `run` rose equals the inputs consumed by all completed periods plus k''+1. A write is issued whenever the written count does not exceed k''.
- R5: `step` is an unsigned 70-bit value with 48 fractional bits equal to T2/T3. The position of output k within its period is k'(real) = k*step, with k' = floor(position). `tap_base` = floor(k'/M), truncated to 16 bits.
- R6: `frac_out` equals position bits [47:32], the top 16 bits of the part below the grid.
- R7: M = 2^`osr_sel` with `osr_sel` in 0..3, and `branch_idx` = k' mod M; its bits at and above `osr_sel` are always 0.
- R8: With `period_len` = N nonzero, output N of a period is computed at position 0 again. At that rebase the written count drops by round(N*step)/M. `period_len` = 0 never rebases.
- R9: With step below M, more outputs than writes are produced over a run; with step above M, more writes than outputs.
- R10: `branch_idx`, `tap_base` and `frac_out` change only in cycles where `cmp_stb` is high and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable; low clears the timing state |
| osr_sel | input | 2 | log2 of the oversampling factor M |
| step | input | 70 | Output spacing over grid spacing, 48 fractional bits |
| period_len | input | 10 | Outputs per exact period; 0 disables rebasing |
| wr_stb | output | 1 | Shift one input sample into the register bank |
| cmp_stb | output | 1 | Compute one output sample now |
| branch_idx | output | 3 | Polyphase branch for the current output |
| tap_base | output | 16 | Base tap offset k'' |
| frac_out | output | 16 | Linear interpolation weight |

## Verification
A wrong position accumulator first shows in `frac_out` or `branch_idx` on the very next compute strobe. Some errors only move the position by a little; these cross a grid boundary within a few outputs and then appear as a shifted branch or as an extra or missing write. A wrong input count or a bad rebase does not disturb the indices; it shows as a write count that differs from the expected total at the first compute after the damage, which for period rebasing is the first output of the next period. The bench compares every compute strobe against exact rational positions, so none of these can stay hidden longer than one period.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  // Action chosen by the sequencer for one enabled cycle
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_WRITE   = 2'd1,
    ACT_COMPUTE = 2'd2
  } act_e;

endpackage

// File: rtl/rsc_phase_acc.sv
// Output position on the coefficient grid, with period rebasing.
module rsc_phase_acc #(
  parameter int TIME_W = 70,
  parameter int FRAC_W = 48,
  parameter int CNT_W  = 10,
  localparam int INT_W = TIME_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic [TIME_W-1:0] step,
  input  logic [CNT_W-1:0]  period_len,
  output logic [TIME_W-1:0] pos,
  output logic              rebase,
  output logic [INT_W-1:0]  rebase_grid
);

  localparam logic [TIME_W-1:0] HALF = TIME_W'(1) << (FRAC_W - 1);

  logic [TIME_W-1:0] pos_q;
  logic [TIME_W-1:0] pos_next;
  logic [TIME_W-1:0] pos_round;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_next;
  logic              period_hit;

  assign pos_next   = pos_q + step;
  assign cnt_next   = cnt_q + CNT_W'(1);
  assign period_hit = (period_len != '0) && (cnt_next == period_len);
  assign pos_round  = pos_next + HALF;

  assign rebase      = adv && period_hit;
  assign rebase_grid = pos_round[TIME_W-1:FRAC_W];
  assign pos         = pos_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else if (adv) begin
      if (period_hit) begin
        pos_q <= '0;
        cnt_q <= '0;
      end else begin
        pos_q <= pos_next;
        cnt_q <= cnt_next;
      end
    end
  end

endmodule

// File: rtl/rsc_split.sv
// Splits the grid position into branch, base tap and weight for the chosen M.
module rsc_split #(
  parameter int TIME_W    = 70,
  parameter int FRAC_W    = 48,
  parameter int A_W       = 16,
  parameter int MAX_LOG2M = 3,
  parameter int KB_W      = 16,
  localparam int INT_W = TIME_W - FRAC_W,
  localparam int SEL_W = $clog2(MAX_LOG2M + 1),
  localparam int BR_W  = (MAX_LOG2M < 1) ? 1 : MAX_LOG2M
) (
  input  logic [TIME_W-1:0] pos,
  input  logic [SEL_W-1:0]  osr_sel,
  input  logic [INT_W-1:0]  rebase_grid,
  output logic [BR_W-1:0]   branch,
  output logic [KB_W-1:0]   kbase,
  output logic [A_W-1:0]    frac,
  output logic [INT_W-1:0]  rebase_inputs
);

  logic [INT_W-1:0] kp;
  logic [BR_W-1:0]  br_opt [MAX_LOG2M+1];
  logic [KB_W-1:0]  kb_opt [MAX_LOG2M+1];
  logic [INT_W-1:0] rb_opt [MAX_LOG2M+1];
  logic [SEL_W-1:0] sel_c;
  logic             unused_low_bits;

  assign kp              = pos[TIME_W-1:FRAC_W];
  assign frac            = pos[FRAC_W-1 -: A_W];
  assign unused_low_bits = ^pos[FRAC_W-A_W-1:0];

  // One fixed slicing per supported oversampling factor
  for (genvar g = 0; g <= MAX_LOG2M; g++) begin : g_opt
    localparam logic [INT_W-1:0] MASK = INT_W'((64'd1 << g) - 64'd1);
    assign br_opt[g] = BR_W'(kp & MASK);
    assign kb_opt[g] = KB_W'(kp >> g);
    assign rb_opt[g] = rebase_grid >> g;
  end

  always_comb begin
    if (int'(osr_sel) > MAX_LOG2M) sel_c = SEL_W'(MAX_LOG2M);
    else                           sel_c = osr_sel;
  end

  assign branch        = br_opt[sel_c];
  assign kbase         = kb_opt[sel_c];
  assign rebase_inputs = rb_opt[sel_c];

endmodule

// File: rtl/rsc_input_track.sv
// Signed count of input samples written relative to the current period base.
module rsc_input_track #(
  parameter int KB_W  = 16,
  parameter int INT_W = 22,
  localparam int NW_W = KB_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr,
  input  logic             rebase,
  input  logic [INT_W-1:0] rebase_inputs,
  input  logic [KB_W-1:0]  kbase,
  output logic             need_write
);

  logic signed [NW_W-1:0] written_q;
  logic signed [NW_W-1:0] kbase_s;
  logic signed [NW_W-1:0] sub_s;

  assign kbase_s    = $signed({2'b00, kbase});
  assign sub_s      = $signed(NW_W'(rebase_inputs));
  assign need_write = (written_q <= kbase_s);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      written_q <= '0;
    end else if (wr) begin
      written_q <= written_q + NW_W'(1);
    end else if (rebase) begin
      written_q <= written_q - sub_s;
    end
  end

endmodule

// File: rtl/rsc_timing_ctrl.sv
// Top: one strobe per enabled cycle, registered index outputs.
module rsc_timing_ctrl #(
  parameter int TIME_W    = 70,
  parameter int FRAC_W    = 48,
  parameter int A_W       = 16,
  parameter int MAX_LOG2M = 3,
  parameter int KB_W      = 16,
  parameter int CNT_W     = 10,
  localparam int INT_W = TIME_W - FRAC_W,
  localparam int SEL_W = $clog2(MAX_LOG2M + 1),
  localparam int BR_W  = (MAX_LOG2M < 1) ? 1 : MAX_LOG2M
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [SEL_W-1:0]  osr_sel,
  input  logic [TIME_W-1:0] step,
  input  logic [CNT_W-1:0]  period_len,
  output logic              wr_stb,
  output logic              cmp_stb,
  output logic [BR_W-1:0]   branch_idx,
  output logic [KB_W-1:0]   tap_base,
  output logic [A_W-1:0]    frac_out
);

  import rsc_pkg::*;

  act_e              act;
  logic              clr;
  logic              do_wr;
  logic              do_cmp;
  logic              need_write;
  logic [TIME_W-1:0] pos;
  logic              rebase;
  logic [INT_W-1:0]  rebase_grid;
  logic [INT_W-1:0]  rebase_inputs;
  logic [BR_W-1:0]   branch_c;
  logic [KB_W-1:0]   kbase_c;
  logic [A_W-1:0]    frac_c;

  assign clr = !run;

  always_comb begin
    act = ACT_NONE;
    if (run) act = need_write ? ACT_WRITE : ACT_COMPUTE;
  end

  assign do_wr  = (act == ACT_WRITE);
  assign do_cmp = (act == ACT_COMPUTE);

  rsc_phase_acc #(
    .TIME_W(TIME_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)
  ) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .adv(do_cmp),
    .step(step), .period_len(period_len),
    .pos(pos), .rebase(rebase), .rebase_grid(rebase_grid)
  );

  rsc_split #(
    .TIME_W(TIME_W), .FRAC_W(FRAC_W), .A_W(A_W),
    .MAX_LOG2M(MAX_LOG2M), .KB_W(KB_W)
  ) u_split (
    .pos(pos), .osr_sel(osr_sel), .rebase_grid(rebase_grid),
    .branch(branch_c), .kbase(kbase_c), .frac(frac_c),
    .rebase_inputs(rebase_inputs)
  );

  rsc_input_track #(
    .KB_W(KB_W), .INT_W(INT_W)
  ) u_track (
    .clk(clk), .rst(rst), .clr(clr), .wr(do_wr),
    .rebase(rebase), .rebase_inputs(rebase_inputs),
    .kbase(kbase_c), .need_write(need_write)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb     <= 1'b0;
      cmp_stb    <= 1'b0;
      branch_idx <= '0;
      tap_base   <= '0;
      frac_out   <= '0;
    end else begin
      wr_stb  <= do_wr;
      cmp_stb <= do_cmp;
      if (do_cmp) begin
        branch_idx <= branch_c;
        tap_base   <= kbase_c;
        frac_out   <= frac_c;
      end
    end
  end

endmodule

// File: rtl/rsc_timing_ctrl_chk.sv
module rsc_timing_ctrl_chk #(
  parameter int SEL_W = 2,
  parameter int BR_W  = 3,
  parameter int KB_W  = 16,
  parameter int A_W   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic [SEL_W-1:0] osr_sel,
  input logic             wr_stb,
  input logic             cmp_stb,
  input logic [BR_W-1:0]  branch_idx,
  input logic [KB_W-1:0]  tap_base,
  input logic [A_W-1:0]   frac_out
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_stb && !cmp_stb && branch_idx == '0 &&
                    tap_base == '0 && frac_out == '0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (!wr_stb && !cmp_stb));

  // R3
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && cmp_stb));

  // R3
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(rst)) |-> (wr_stb || cmp_stb));

  // R7
  branch_range_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_stb |-> ((branch_idx >> $past(osr_sel)) == '0));

  // R10
  index_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !cmp_stb) |->
      ($stable(branch_idx) && $stable(tap_base) && $stable(frac_out)));

endmodule

bind rsc_timing_ctrl rsc_timing_ctrl_chk #(
  .SEL_W(SEL_W), .BR_W(BR_W), .KB_W(KB_W), .A_W(A_W)
) u_chk (
  .clk(clk), .rst(rst), .run(run), .osr_sel(osr_sel),
  .wr_stb(wr_stb), .cmp_stb(cmp_stb), .branch_idx(branch_idx),
  .tap_base(tap_base), .frac_out(frac_out)
);

// File: tb/rsc_timing_ctrl_tb.sv
module rsc_timing_ctrl_tb;

  localparam int TIME_W = 70;
  localparam int FRAC_W = 48;
  localparam int A_W    = 16;
  localparam int KB_W   = 16;
  localparam int CNT_W  = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              run = 1'b0;
  logic [1:0]        osr_sel = '0;
  logic [TIME_W-1:0] step = '0;
  logic [CNT_W-1:0]  period_len = '0;
  logic              wr_stb;
  logic              cmp_stb;
  logic [2:0]        branch_idx;
  logic [KB_W-1:0]   tap_base;
  logic [A_W-1:0]    frac_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rsc_timing_ctrl u_dut (
    .clk(clk), .rst(rst), .run(run), .osr_sel(osr_sel), .step(step),
    .period_len(period_len), .wr_stb(wr_stb), .cmp_stb(cmp_stb),
    .branch_idx(branch_idx), .tap_base(tap_base), .frac_out(frac_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Step rounded up so the accumulated position never falls below the exact one
  function automatic logic [TIME_W-1:0] step_of(input int num, input int den);
    logic [127:0] q;
    q = ((128'(num) << FRAC_W) + 128'(den - 1)) / 128'(den);
    return q[TIME_W-1:0];
  endfunction

  task automatic run_case(input int num, input int den, input int lg,
                          input int plen, input int n_out);
    longint m = longint'(1) << lg;
    longint writes = 0;
    longint outs = 0;
    int     cyc = 0;
    int     bad_one = 0;
    int     bad_hold = 0;
    logic [2:0]      last_br;
    logic [KB_W-1:0] last_kb;
    logic [A_W-1:0]  last_fr;
    @(negedge clk);
    last_br = branch_idx; last_kb = tap_base; last_fr = frac_out;
    step = step_of(num, den);
    osr_sel = 2'(lg);
    period_len = CNT_W'(plen);
    run = 1'b1;
    while (outs < n_out && cyc < 8000) begin
      @(negedge clk);
      cyc++;
      if (int'(wr_stb) + int'(cmp_stb) != 1) bad_one++;
      if (wr_stb) writes++;
      if (cmp_stb) begin
        longint kl, per, pn, kp, r, ea, per_in, ewr;
        kl = (plen != 0) ? outs % plen : outs;
        per = (plen != 0) ? outs / plen : 0;
        pn = kl * num;
        kp = pn / den;
        r = pn % den;
        ea = (r * 65536) / den;
        per_in = (plen != 0) ? (longint'(plen) * num / den) / m : 0;
        ewr = per * per_in + kp / m + 1;
        check(writes == ewr, "R4", "writes before output", writes, ewr);
        check(longint'(tap_base) == kp / m, "R5", "tap base", tap_base, kp / m);
        check(longint'(branch_idx) == kp % m, "R7", "branch", branch_idx, kp % m);
        check(longint'(frac_out) == ea, "R6", "fraction", frac_out, ea);
        if (kl == 0 && per > 0)
          check(branch_idx == 0 && tap_base == 0 && frac_out == 0, "R8",
                "restart position", longint'(tap_base) * 8 + branch_idx, 0);
        last_br = branch_idx; last_kb = tap_base; last_fr = frac_out;
        outs++;
      end else begin
        if (branch_idx != last_br || tap_base != last_kb || frac_out != last_fr)
          bad_hold++;
      end
    end
    run = 1'b0;
    check(outs == n_out, "R3", "outputs reached", outs, n_out);
    check(bad_one == 0, "R3", "cycles without exactly one strobe", bad_one, 0);
    check(bad_hold == 0, "R10", "index changes without compute", bad_hold, 0);
    if (num < den * m)
      check(outs > writes, "R9", "upsampling outputs exceed writes", outs, writes + 1);
    else if (num > den * m)
      check(writes > outs, "R9", "downsampling writes exceed outputs", writes, outs + 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!wr_stb && !cmp_stb, "R2", "strobe while idle",
            int'(wr_stb) + int'(cmp_stb), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    check(!wr_stb && !cmp_stb && branch_idx == 0 && tap_base == 0 && frac_out == 0,
          "R1", "reset outputs", int'(wr_stb) + int'(cmp_stb) + branch_idx, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!wr_stb && !cmp_stb, "R2", "idle after reset",
          int'(wr_stb) + int'(cmp_stb), 0);
    // Directed corners
    run_case(1, 3, 3, 0, 150);    // heavy upsampling, no rebase, repeating fraction
    run_case(8, 1, 3, 8, 60);     // integer ratio: one write per output
    run_case(37, 2, 2, 8, 80);    // downsampling by 4.625
    run_case(5, 7, 0, 7, 90);     // M = 1, upsampling
    run_case(3, 1, 1, 2, 60);     // M = 2, downsampling by 1.5
    // Random ratios in both directions
    for (int c = 0; c < 8; c++) begin
      int lg, den, num, m;
      lg = int'($urandom % 4);
      m = 1 << lg;
      den = 1 + int'($urandom % 7);
      num = 1 + int'($urandom % (4 * den * m));
      run_case(num, den, lg, den * m, 120);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule